// File: doc/BRIEF.md
# Dual-Channel Timer Input Capture

This block is the capture section of a 16-bit free-running timer. It has two independent channels. Each channel watches its own input pin for a software-selected edge. On that edge it copies the counter value it is given into a read-only capture register. Software reads each capture register over an 8-bit register bus, first the upper byte and then the lower byte.

Each channel owns a capture flag. One shared enable bit lets the flags raise a single interrupt request, and a CPU-side mask input can hold that request back. A flag is cleared by a two-step sequence: a read of the status register while the flag is set, then any access to that channel's lower byte. Reading a channel's upper byte freezes that channel until the lower byte is touched, so the two halves always belong to one capture. A mode input tells the block that the timer is generating PWM or single pulses. In that mode only the second channel captures.

The pins need no enable. They pass through a two-flop synchronizer and an edge detector in the timer clock domain, so the counter value taken is the one present at the third rising clock edge after a pin changes.

Top module: `tcap_capture_unit`

## Requirements
- R1: After reset, the control register, the status register and all four capture bytes read as zero, and `irq` is low.
- R2: Control bit 0 selects the active edge of channel 1 and bit 1 selects it for channel 2: 1 means rising and 0 means falling. A transition of the other polarity captures nothing and sets no flag.
- R3: On an active edge, the channel's capture register takes the `cnt_val` present at the third rising clock edge after the pin changes. The channel's status bit is set: bit 0 for channel 1, bit 1 for channel 2.
- R4: A channel's flag clears after a status read (address 1) made while that flag is set, followed by a read or a write of the channel's lower byte. That byte is at address 3 for channel 1 and address 5 for channel 2.
- R5: A lower-byte access with no earlier status read taken while the flag was set leaves the flag set. A status read made while the flag is clear does not arm the clear.
- R6: A read of a channel's upper byte (address 2 for channel 1, address 4 for channel 2) blocks captures and flag setting on that channel. Edges that arrive in that time are dropped. The block lifts at the next access to that channel's lower byte.
- R7: `irq` is high exactly when control bit 2 (interrupt enable) is set, at least one flag is set, and `irq_mask` is low. While the mask is high the request stays pending.
- R8: While `pwm_mode` is high, channel 1 ignores its pin and keeps its register and flag, and channel 2 captures normally.
- R9: The control register at address 0 reads back bits 2..0 as written, and its upper bits read zero. Writes to the status or capture addresses change no stored value. Unused addresses read zero.
- R10: A capture register keeps its value until the next accepted capture on that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | 16 | Free-running counter value |
| cap_pin | input | 2 | Capture pins, bit 0 = channel 1 |
| pwm_mode | input | 1 | High while PWM or one-pulse generation runs |
| irq_mask | input | 1 | CPU interrupt mask, high blocks `irq` |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| irq | output | 1 | Shared capture interrupt request |

## Verification
Errors in the internal state show up at the ports in a few cycles.

- A stuck lock state shows up as a capture byte that stops following pin edges. It is visible at the first lower-byte read after the next qualifying edge.
- A wrong arming state shows up as a status bit that survives or vanishes at the wrong lower-byte access. It is visible on the next status read.
- A wrong synchronizer depth shifts the captured counter value by whole ticks. A bench that advances the counter every cycle sees it in the first captured byte pair.
- Errors in the enable or flag state reach `irq` in the same cycle.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

   localparam int unsigned TCAP_NUM_CH = 2;

   // register address map; capture byte pairs follow from CAP_BASE
   localparam int unsigned ADR_CTRL     = 0;
   localparam int unsigned ADR_STATUS   = 1;
   localparam int unsigned ADR_CAP_BASE = 2;

   // control register bit positions
   localparam int unsigned CTRL_IE_BIT  = TCAP_NUM_CH;
   localparam int unsigned CTRL_W       = TCAP_NUM_CH + 1;

   typedef struct packed {
      logic                   stat_rd;
      logic [TCAP_NUM_CH-1:0] hi_rd;
      logic [TCAP_NUM_CH-1:0] lo_acc;
   } tcap_strobe_t;

   function automatic int unsigned hi_addr(input int unsigned ch);
      return ADR_CAP_BASE + 2 * ch;
   endfunction

   function automatic int unsigned lo_addr(input int unsigned ch);
      return ADR_CAP_BASE + 2 * ch + 1;
   endfunction

endpackage

// File: rtl/tcap_edge_sync.sv
module tcap_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rise_sel,
   output logic edge_hit
);

   generate
      if (STAGES < 2) begin : g_err_stages
         $error("tcap_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              prev_q;
   logic              cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign cur = sync_q[STAGES-1];

   always_comb begin
      if (rise_sel) edge_hit = cur & ~prev_q;
      else          edge_hit = ~cur & prev_q;
   end

endmodule

// File: rtl/tcap_channel.sv
module tcap_channel #(
   parameter int unsigned CNT_W       = 16,
   parameter bit          RUN_IN_PWM  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_hit,
   input  logic             pwm_mode,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             stat_rd,
   input  logic             hi_rd,
   input  logic             lo_acc,
   output logic [CNT_W-1:0] cap_q,
   output logic             flag_q,
   output logic             lock_q
);

   logic run_en;
   logic accept;
   logic armed_q;

   generate
      if (RUN_IN_PWM) begin : g_always_on
         assign run_en = 1'b1;
      end else begin : g_gated_by_pwm
         assign run_en = ~pwm_mode;
      end
   endgenerate

   assign accept = edge_hit & ~lock_q & run_en;

   // capture register: loads only on an accepted edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cap_q <= '0;
      else if (accept) cap_q <= cnt_val;
   end

   // flag: a new capture wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  flag_q <= 1'b0;
      else if (accept)             flag_q <= 1'b1;
      else if (lo_acc && armed_q)  flag_q <= 1'b0;
   end

   // arming: remembers whether the flag was set at the status read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed_q <= 1'b0;
      else if (lo_acc)  armed_q <= 1'b0;
      else if (stat_rd) armed_q <= flag_q;
   end

   // lock: upper-byte read freezes the channel until the lower byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lock_q <= 1'b0;
      else if (lo_acc) lock_q <= 1'b0;
      else if (hi_rd)  lock_q <= 1'b1;
   end

endmodule

// File: rtl/tcap_regs.sv
module tcap_regs
   import tcap_pkg::*;
#(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned NUM_CH = TCAP_NUM_CH
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_sel,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [BUS_W-1:0]        bus_wdata,
   input  logic [NUM_CH*CNT_W-1:0] cap_flat,
   input  logic [NUM_CH-1:0]       flags,
   output logic [BUS_W-1:0]        bus_rdata,
   output logic [NUM_CH-1:0]       rise_sel,
   output logic                    irq_en,
   output tcap_strobe_t            strb
);

   localparam int unsigned LAST_ADR = ADR_CAP_BASE + 2 * NUM_CH - 1;

   generate
      if (LAST_ADR >= (1 << ADDR_W)) begin : g_err_addr
         $error("tcap_regs: ADDR_W too small for the register map");
      end
      if (BUS_W < CTRL_W) begin : g_err_bus
         $error("tcap_regs: BUS_W too narrow for the control register");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   logic              rd_en;
   logic              wr_ctrl;
   int unsigned       adr;
   logic              unused_wdata;

   assign adr     = int'(bus_addr);
   assign rd_en   = bus_sel & ~bus_wr;
   assign wr_ctrl = bus_sel & bus_wr & (adr == ADR_CTRL);

   assign unused_wdata = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
   end

   assign rise_sel = ctrl_q[NUM_CH-1:0];
   assign irq_en   = ctrl_q[CTRL_IE_BIT];

   // access strobes for the channels
   assign strb.stat_rd = rd_en & (adr == ADR_STATUS);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_strb
         assign strb.hi_rd[gi]  = rd_en & (adr == hi_addr(gi));
         assign strb.lo_acc[gi] = bus_sel & (adr == lo_addr(gi));
      end
   endgenerate

   // read data multiplexer, combinational in the access cycle
   always_comb begin
      bus_rdata = '0;
      if (adr == ADR_CTRL) begin
         bus_rdata[CTRL_W-1:0] = ctrl_q;
      end else if (adr == ADR_STATUS) begin
         bus_rdata[NUM_CH-1:0] = flags;
      end else begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (adr == hi_addr(c))
               bus_rdata = cap_flat[c*CNT_W + BUS_W +: BUS_W];
            else if (adr == lo_addr(c))
               bus_rdata = cap_flat[c*CNT_W +: BUS_W];
         end
      end
   end

endmodule

// File: rtl/tcap_capture_unit.sv
module tcap_capture_unit
   import tcap_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned BUS_W       = 8,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [CNT_W-1:0]       cnt_val,
   input  logic [TCAP_NUM_CH-1:0] cap_pin,
   input  logic                   pwm_mode,
   input  logic                   irq_mask,
   input  logic                   bus_sel,
   input  logic                   bus_wr,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [BUS_W-1:0]       bus_wdata,
   output logic [BUS_W-1:0]       bus_rdata,
   output logic                   irq
);

   localparam int unsigned NUM_CH = TCAP_NUM_CH;

   generate
      if (CNT_W != 2 * BUS_W) begin : g_err_width
         $error("tcap_capture_unit: CNT_W must be two bus bytes wide");
      end
   endgenerate

   logic [NUM_CH-1:0]       rise_sel;
   logic [NUM_CH-1:0]       edge_hit;
   logic [NUM_CH-1:0]       flag_v;
   logic [NUM_CH-1:0]       lock_v;
   logic [NUM_CH*CNT_W-1:0] cap_flat;
   logic                    irq_en;
   tcap_strobe_t            strb;

   genvar gc;
   generate
      for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
         tcap_edge_sync #(
            .STAGES (SYNC_STAGES)
         ) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (cap_pin[gc]),
            .rise_sel (rise_sel[gc]),
            .edge_hit (edge_hit[gc])
         );

         // channel 1 (index 0) is idle during PWM / one-pulse operation
         tcap_channel #(
            .CNT_W      (CNT_W),
            .RUN_IN_PWM (gc != 0)
         ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .edge_hit (edge_hit[gc]),
            .pwm_mode (pwm_mode),
            .cnt_val  (cnt_val),
            .stat_rd  (strb.stat_rd),
            .hi_rd    (strb.hi_rd[gc]),
            .lo_acc   (strb.lo_acc[gc]),
            .cap_q    (cap_flat[gc*CNT_W +: CNT_W]),
            .flag_q   (flag_v[gc]),
            .lock_q   (lock_v[gc])
         );
      end
   endgenerate

   tcap_regs #(
      .BUS_W  (BUS_W),
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .NUM_CH (NUM_CH)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .cap_flat  (cap_flat),
      .flags     (flag_v),
      .bus_rdata (bus_rdata),
      .rise_sel  (rise_sel),
      .irq_en    (irq_en),
      .strb      (strb)
   );

   assign irq = irq_en & (|flag_v) & ~irq_mask;

endmodule

// File: rtl/tcap_checker.sv
module tcap_checker #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwm_mode,
   input logic             irq_mask,
   input logic             irq,
   input logic [1:0]       flag,
   input logic [1:0]       lock,
   input logic [1:0]       lo_acc,
   input logic [CNT_W-1:0] cap0,
   input logic [CNT_W-1:0] cap1
);

   // R7: the mask always holds the request back
   a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mask |-> !irq);

   // R7: no flag, no request
   a_r7_no_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (flag == 2'b00) |-> !irq);

   // R8: channel 1 flag never rises out of a PWM cycle
   a_r8_pwm_ch1_silent: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[0]) |-> !$past(pwm_mode));

   // R8: channel 1 register is frozen during PWM
   a_r8_pwm_ch1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_mode |=> $stable(cap0));

   // R4: a flag only falls after a lower-byte access
   a_r4_fall_ch1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[0]) |-> $past(lo_acc[0]));
   a_r4_fall_ch2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[1]) |-> $past(lo_acc[1]));

   // R6: a locked channel keeps its register and cannot raise its flag
   a_r6_lock_hold_ch1: assert property (@(posedge clk) disable iff (!rst_n)
      lock[0] |=> $stable(cap0));
   a_r6_lock_hold_ch2: assert property (@(posedge clk) disable iff (!rst_n)
      lock[1] |=> $stable(cap1));
   a_r6_lock_noflag_ch1: assert property (@(posedge clk) disable iff (!rst_n)
      (lock[0] && !flag[0]) |=> !flag[0]);
   a_r6_lock_noflag_ch2: assert property (@(posedge clk) disable iff (!rst_n)
      (lock[1] && !flag[1]) |=> !flag[1]);

   // R10: a register change always comes with a set flag
   a_r10_change_sets_flag_ch2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap1) |-> flag[1]);

endmodule

bind tcap_capture_unit tcap_checker #(
   .CNT_W (CNT_W)
) u_tcap_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pwm_mode (pwm_mode),
   .irq_mask (irq_mask),
   .irq      (irq),
   .flag     (flag_v),
   .lock     (lock_v),
   .lo_acc   (strb.lo_acc),
   .cap0     (cap_flat[CNT_W-1:0]),
   .cap1     (cap_flat[2*CNT_W-1:CNT_W])
);

// File: tb/tb_tcap_capture_unit.sv
`timescale 1ns/1ps
module tb_tcap_capture_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cnt_val = '0;
   logic [1:0]  cap_pin = '0;
   logic        pwm_mode = 1'b0;
   logic        irq_mask = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        irq;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;

   // bench model of the requirements
   logic [1:0]  m_rise = '0;
   logic        m_ie = 1'b0;
   logic [1:0]  m_flag = '0;
   logic [1:0]  m_arm = '0;
   logic [1:0]  m_lock = '0;
   logic [15:0] m_val [2] = '{16'h0, 16'h0};

   tcap_capture_unit dut (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cap_pin(cap_pin),
      .pwm_mode(pwm_mode), .irq_mask(irq_mask), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   always #5 clk = ~clk;

   function automatic logic exp_irq();
      return m_ie & (|m_flag) & ~irq_mask;
   endfunction

   function automatic logic [15:0] exp_capture(input logic [15:0] v0);
      return v0 + 16'd2;
   endfunction

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_access(input logic [2:0] a, input logic is_wr, input logic [7:0] d);
      if (a == 3'd0 && is_wr) begin
         m_rise = d[1:0];
         m_ie   = d[2];
      end
      if (a == 3'd1 && !is_wr) m_arm = m_flag;
      for (int c = 0; c < 2; c++) begin
         if (a == 3'(2 + 2*c) && !is_wr) m_lock[c] = 1'b1;
         if (a == 3'(3 + 2*c)) begin
            if (m_arm[c]) m_flag[c] = 1'b0;
            m_arm[c]  = 1'b0;
            m_lock[c] = 1'b0;
         end
      end
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      model_access(a, 1'b0, 8'h0);
      @(posedge clk); #1;
      bus_sel = 1'b0;
   endtask

   task automatic bus_wrt(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      model_access(a, 1'b1, d);
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   // change a pin with the counter advancing every cycle
   task automatic pin_edge(input int ch, input logic lvl, input logic [15:0] v0);
      @(negedge clk);
      cap_pin[ch] = lvl;
      cnt_val = v0;
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         cnt_val = v0 + 16'(k);
      end
      if (lvl == m_rise[ch] && !m_lock[ch] && !(ch == 0 && pwm_mode)) begin
         m_flag[ch] = 1'b1;
         m_val[ch]  = exp_capture(v0);
      end
   endtask

   task automatic check_status(input string req);
      logic [7:0] d;
      bus_rd(3'd1, d);
      chk({8'h0, d}, {14'h0, m_flag}, req);
   endtask

   task automatic check_cap(input int ch, input string req);
      logic [7:0] hi, lo;
      logic [15:0] want;
      want = m_val[ch];
      bus_rd(3'(2 + 2*ch), hi);
      bus_rd(3'(3 + 2*ch), lo);
      chk({hi, lo}, want, req);
   endtask

   task automatic check_irq(input string req);
      @(negedge clk); #1;
      chk({15'h0, irq}, {15'h0, exp_irq()}, req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 6; a++) begin
         bus_rd(3'(a), d);
         chk({8'h0, d}, 16'h0, "R1 reset register");
      end
      check_irq("R1 reset irq");

      // R9: control readback, upper bits zero, unused address zero
      bus_wrt(3'd0, 8'hFF);
      bus_rd(3'd0, d);
      chk({8'h0, d}, 16'h0007, "R9 ctrl readback");
      bus_rd(3'd7, d);
      chk({8'h0, d}, 16'h0, "R9 unused address");
      bus_wrt(3'd0, 8'h07);

      // R3: channel 1 rising capture, exact counter value
      pin_edge(0, 1'b1, 16'h1230);
      chk(m_val[0], 16'h1232, "R3 expected value");
      check_irq("R7 irq raised");
      irq_mask = 1'b1;
      check_irq("R7 masked");
      irq_mask = 1'b0;
      check_irq("R7 pending after unmask");
      check_status("R3 status flag ch1");
      check_cap(0, "R3 captured value ch1");
      check_status("R4 clear by status then low byte");

      // R9: writes to capture / status addresses store nothing
      bus_wrt(3'd2, 8'hAA);
      bus_wrt(3'd1, 8'h03);
      check_status("R9 status write ignored");
      check_cap(0, "R9 capture write ignored");

      // R2: falling transition with rising selected
      pin_edge(0, 1'b0, 16'h4000);
      check_status("R2 wrong edge no flag");
      check_cap(0, "R2 wrong edge no capture");
      bus_wrt(3'd0, 8'h06);
      pin_edge(0, 1'b1, 16'h5000);
      check_status("R2 rising ignored when falling selected");
      pin_edge(0, 1'b0, 16'h6100);
      check_status("R2 falling captured");
      check_cap(0, "R2 falling value");
      check_status("R4 clear ch1 again");

      // R5: low-byte access without an armed status read
      pin_edge(1, 1'b1, 16'hBEE0);
      bus_rd(3'd5, d);
      check_status("R5 flag survives unarmed low access");
      chk({14'h0, m_flag}, 16'h0002, "R5 expected flag kept");
      // R4: write access to low byte also completes the clear
      check_status("R4 arm ch2");
      bus_wrt(3'd5, 8'h00);
      check_status("R4 write access clears");

      // R6: upper-byte read locks channel 2
      bus_rd(3'd4, d);
      chk({8'h0, d}, {8'h0, m_val[1][15:8]}, "R6 upper byte");
      pin_edge(1, 1'b0, 16'h0000);
      pin_edge(1, 1'b1, 16'h7770);
      check_status("R6 no flag while locked");
      bus_rd(3'd5, d);
      chk({8'h0, d}, 16'h00E2, "R6 low byte keeps old capture");
      pin_edge(1, 1'b0, 16'h0000);
      pin_edge(1, 1'b1, 16'h8880);
      check_status("R6 captures after unlock");
      check_cap(1, "R6 value after unlock");
      check_status("R4 clear ch2");

      // R8: PWM mode blocks channel 1 only
      pwm_mode = 1'b1;
      pin_edge(0, 1'b1, 16'h9990);
      pin_edge(0, 1'b0, 16'h9A90);
      check_status("R8 ch1 idle in pwm");
      check_cap(0, "R8 ch1 value kept");
      pin_edge(1, 1'b0, 16'h0000);
      pin_edge(1, 1'b1, 16'hC0D0);
      check_status("R8 ch2 active in pwm");
      check_cap(1, "R8 ch2 value");
      check_status("R4 clear in pwm");
      pwm_mode = 1'b0;

      // R10 plus random mix of edges, polarities, masks and reads
      for (int it = 0; it < 40; it++) begin
         int ch;
         ch = int'($urandom % 2);
         if ($urandom % 4 == 0) bus_wrt(3'd0, {5'h0, 1'b1, 2'($urandom)});
         pin_edge(ch, ~cap_pin[ch], 16'($urandom));
         irq_mask = 1'($urandom);
         check_irq("R7 random irq");
         check_status("R3 random status");
         if ($urandom % 2 == 1) check_cap(ch, "R10 random capture value");
         if ($urandom % 3 == 0) check_cap(1 - ch, "R10 other channel held");
      end
      irq_mask = 1'b0;

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule